// File: doc/BRIEF.md
# Receive Buffer Writer With Completion

This block takes the word stream of a packet that has already passed address filtering and places it into a memory buffer through a plain write port made of address, data and write enable. Software-side logic starts it once per packet with a buffer length in words and a base address. The stream carries data words, then the check word (CRC), then a hardware status word. The status word is marked by an end-of-packet attention flag that comes with it.

Every word is held for one step and written only when the next word arrives. The check word is therefore still in the holding register when the status word arrives. If the buffer has room, the check word is written, but it is never counted in the reported length. At the end the block emits a one-cycle completion pulse together with a 16-bit completion word and a words-used count. The completion word carries a result code in its upper byte and the low byte of the hardware status in its lower byte.

There is one special boundary case. A buffer that is exactly full, followed at once by the status word, ends as a success. A data word that arrives when there is no room left is an overflow. After an overflow the block drops everything up to and including the next status word.

Top module: `rx_buf_writer`

## Requirements
- R1: During and directly after reset, `mem_we_o`, `done_o` and `busy_o` are 0.
- R2: When idle, a `start_i` pulse latches `buf_len_i` and `buf_base_i` and raises `busy_o`. A `start_i` that arrives while busy changes neither the buffer length nor the base address used by the packet in progress.
- R3: Data word k of a packet (k counted from 0) is written at address `buf_base + k`, modulo 2^ADDR_W. The write appears one cycle after the edge that accepts the word following it. Accepted words are written in order, with no gaps and no repeats.
- R4: For a packet of n data words with 1 ≤ n ≤ buffer length, all n words are written, including the trailing check word. `words_used_o` reports n−1.
- R5: A normal end gives `completion_o` = {8'h01, status[7:0]}, where status is the word that carries `in_eop_i`. `done_o` is high for exactly one cycle. When the trailing check word is written, its write falls in the same cycle as `done_o`.
- R6: If exactly buffer length + 1 data words are followed by the status word, the buffer-length words are written and the last held word is not written. The result is code 8'h01 with `words_used_o` equal to the buffer length.
- R7: If a data word arrives when the buffer is full and a word is already held, `done_o` pulses with `completion_o` = 16'h0200 and `words_used_o` equal to the buffer length. After that, no write and no further `done_o` occur until the status word has been consumed, and then `busy_o` falls.
- R8: A packet whose first word carries `in_eop_i` completes with code 8'h01, `words_used_o` = 0 and no memory write.
- R9: Words presented while idle, including status words, cause no write and no `done_o`.
- R10: Cycles with `in_valid_i` low leave the stream state unchanged. Idle gaps between words do not alter the writes or the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a packet (honoured only when idle) |
| buf_len_i | input | LEN_W | Buffer length in words |
| buf_base_i | input | ADDR_W | Buffer base address |
| in_valid_i | input | 1 | Stream word valid |
| in_eop_i | input | 1 | This word is the hardware status word |
| in_data_i | input | DATA_W | Stream word |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |
| done_o | output | 1 | One-cycle completion pulse |
| completion_o | output | 16 | Result code (upper byte), status (lower byte) |
| words_used_o | output | LEN_W | Reported packet length in words |
| busy_o | output | 1 | A packet is in progress or being dropped |

## Verification
Two events share one cycle: the write of the held check word and the completion pulse. Both are caused by the same status-word edge. The bench sweeps every buffer length from 0 to 4 against data-word counts from 0 to 7, with idle gaps mixed into the stream. For each case it records every write and the completion. When the packet fits, it requires the last write to land in the same cycle as `done_o`. At exactly full and at overflow, it requires that no write accompanies the pulse.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DROP = 2'd2
  } rbw_state_e;

  localparam int unsigned COMP_W = 16;
  localparam logic [7:0]  CODE_DONE = 8'h01;
  localparam logic [7:0]  CODE_OVF  = 8'h02;
endpackage

// File: rtl/rbw_hold_stage.sv
module rbw_hold_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] dout_o
);
  logic              valid_d;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    valid_d = valid_o;
    word_d  = dout_o;
    if (clear_i) begin
      valid_d = 1'b0;
    end else if (load_i) begin
      valid_d = 1'b1;
      word_d  = din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      dout_o  <= '0;
    end else begin
      valid_o <= valid_d;
      if (load_i) dout_o <= word_d;
    end
  end
endmodule

// File: rtl/rbw_fill_ctr.sv
module rbw_fill_ctr #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic [LEN_W-1:0] init_len_i,
  input  logic             step_i,
  output logic [LEN_W-1:0] ptr_o,
  output logic [LEN_W-1:0] len_o,
  output logic             full_o
);
  logic [LEN_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_o;
    if (init_i)      ptr_d = '0;
    else if (step_i) ptr_d = ptr_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o <= '0;
      len_o <= '0;
    end else begin
      if (init_i || step_i) ptr_o <= ptr_d;
      if (init_i)           len_o <= init_len_i;
    end
  end

  assign full_o = (ptr_o == len_o);
endmodule

// File: rtl/rbw_post.sv
module rbw_post #(
  parameter int unsigned LEN_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire_i,
  input  logic [7:0]                code_i,
  input  logic [7:0]                status_i,
  input  logic [LEN_W-1:0]          used_i,
  output logic                      done_o,
  output logic [rbw_pkg::COMP_W-1:0] completion_o,
  output logic [LEN_W-1:0]          used_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      completion_o <= '0;
      used_o       <= '0;
    end else begin
      done_o <= fire_i;
      if (fire_i) begin
        completion_o <= {code_i, status_i};
        used_o       <= used_i;
      end
    end
  end
endmodule

// File: rtl/rx_buf_writer.sv
module rx_buf_writer
  import rbw_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  buf_len_i,
  input  logic [ADDR_W-1:0] buf_base_i,
  input  logic              in_valid_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o,
  output logic [15:0]       completion_o,
  output logic [LEN_W-1:0]  words_used_o,
  output logic              busy_o
);
  localparam int unsigned STAT_W = 8;

  rbw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic              hold_v;
  logic [DATA_W-1:0] hold_w;
  logic [LEN_W-1:0]  ptr, len_q;
  logic              full;

  logic              wr_fire, post_fire, hold_load, hold_clear, ctr_init, ctr_step;
  logic [7:0]        code_d;
  logic [STAT_W-1:0] status_d;
  logic [LEN_W-1:0]  used_d;

  rbw_hold_stage #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .clear_i(hold_clear), .load_i(hold_load),
    .din_i(in_data_i), .valid_o(hold_v), .dout_o(hold_w)
  );

  rbw_fill_ctr #(.LEN_W(LEN_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .init_i(ctr_init), .init_len_i(buf_len_i),
    .step_i(ctr_step), .ptr_o(ptr), .len_o(len_q), .full_o(full)
  );

  rbw_post #(.LEN_W(LEN_W)) post_i (
    .clk(clk), .rst_n(rst_n), .fire_i(post_fire), .code_i(code_d),
    .status_i(status_d), .used_i(used_d), .done_o(done_o),
    .completion_o(completion_o), .used_o(words_used_o)
  );

  // Next-state and control decode
  always_comb begin
    state_d    = state_q;
    wr_fire    = 1'b0;
    post_fire  = 1'b0;
    hold_load  = 1'b0;
    hold_clear = 1'b0;
    ctr_init   = 1'b0;
    ctr_step   = 1'b0;
    code_d     = CODE_DONE;
    status_d   = '0;
    used_d     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_RUN;
          ctr_init   = 1'b1;
          hold_clear = 1'b1;
        end
      end
      ST_RUN: begin
        if (in_valid_i) begin
          if (in_eop_i) begin
            // Held word (if any) is the check word: stored when room, never counted
            post_fire = 1'b1;
            status_d  = in_data_i[STAT_W-1:0];
            state_d   = ST_IDLE;
            if (hold_v) begin
              if (!full) begin
                wr_fire = 1'b1;
                used_d  = ptr;
              end else begin
                used_d  = len_q;
              end
            end
          end else if (!hold_v) begin
            hold_load = 1'b1;
          end else if (!full) begin
            wr_fire   = 1'b1;
            ctr_step  = 1'b1;
            hold_load = 1'b1;
          end else begin
            post_fire = 1'b1;
            code_d    = CODE_OVF;
            used_d    = len_q;
            state_d   = ST_DROP;
          end
        end
      end
      ST_DROP: begin
        if (in_valid_i && in_eop_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      state_q  <= state_d;
      mem_we_o <= wr_fire;
      if (ctr_init) base_q <= buf_base_i;
      if (wr_fire) begin
        mem_addr_o  <= base_q + ADDR_W'(ptr);
        mem_wdata_o <= hold_w;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/rbw_checker.sv
module rbw_checker
  import rbw_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             mem_we_o,
  input logic             done_o,
  input logic [15:0]      completion_o,
  input logic [LEN_W-1:0] words_used_o,
  input logic [LEN_W-1:0] len_q,
  input rbw_state_e       state_q
);
  p_write_needs_packet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(busy_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_used_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (words_used_o <= len_q));

  p_overflow_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && completion_o[15:8] == CODE_OVF) |-> (words_used_o == len_q && completion_o[7:0] == 8'h00));

  p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !mem_we_o);

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(len_q));
endmodule

bind rx_buf_writer rbw_checker #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .mem_we_o(mem_we_o), .done_o(done_o), .completion_o(completion_o),
  .words_used_o(words_used_o), .len_q(len_q), .state_q(state_q)
);

// File: tb/rx_buf_writer_tb_top.sv
`timescale 1ns/1ps
module rx_buf_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  buf_len_i;
  logic [7:0]  buf_base_i;
  logic        in_valid_i;
  logic        in_eop_i;
  logic [15:0] in_data_i;
  logic        mem_we_o;
  logic [7:0]  mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        done_o;
  logic [15:0] completion_o;
  logic [7:0]  words_used_o;
  logic        busy_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rx_buf_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .buf_len_i(buf_len_i),
    .buf_base_i(buf_base_i), .in_valid_i(in_valid_i), .in_eop_i(in_eop_i),
    .in_data_i(in_data_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .done_o(done_o), .completion_o(completion_o),
    .words_used_o(words_used_o), .busy_o(busy_o)
  );

  // Monitor: records writes and completions at the falling edge
  logic [7:0]  wa [0:15];
  logic [15:0] wd [0:15];
  int          wcnt, dcnt;
  logic [15:0] got_comp;
  logic [7:0]  got_used;
  logic        done_with_we;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we_o) begin
        if (wcnt < 16) begin
          wa[wcnt] = mem_addr_o;
          wd[wcnt] = mem_wdata_o;
        end
        wcnt = wcnt + 1;
      end
      if (done_o) begin
        dcnt         = dcnt + 1;
        got_comp     = completion_o;
        got_used     = words_used_o;
        done_with_we = mem_we_o;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    wcnt = 0;
    dcnt = 0;
    got_comp = '0;
    got_used = '0;
    done_with_we = 1'b0;
  endtask

  function automatic logic [15:0] word_of(input int p, input int i);
    return {p[7:0], i[7:0]};
  endfunction

  task automatic send(input logic eop, input logic [15:0] d);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_eop_i   = eop;
    in_data_i  = d;
    @(negedge clk);
    in_valid_i = 1'b0;
    in_eop_i   = 1'b0;
    in_data_i  = 16'hDEAD;
  endtask

  task automatic run_pkt(input int p, input int len, input int n);
    int base;
    int exp_w, exp_used;
    logic [7:0] exp_code;
    logic [15:0] stat;
    base = (p * 37 + 250) % 256;
    stat = {8'h5A, 8'hA0 ^ p[7:0]};
    clear_mon();
    @(negedge clk);
    start_i    = 1'b1;
    buf_len_i  = len[7:0];
    buf_base_i = base[7:0];
    @(negedge clk);
    start_i = 1'b0;
    if (p % 4 == 1) begin
      // R2: a start while busy must not alter length or base
      @(negedge clk);
      start_i    = 1'b1;
      buf_len_i  = 8'd9;
      buf_base_i = base[7:0] + 8'd100;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      if ((i + p) % 3 == 0) @(negedge clk); // R10: idle gap
      send(1'b0, word_of(p, i));
    end
    send(1'b1, stat);
    repeat (3) @(negedge clk);

    if (n == 0) begin
      exp_w = 0; exp_used = 0; exp_code = 8'h01;
    end else if (n <= len) begin
      exp_w = n; exp_used = n - 1; exp_code = 8'h01;
    end else if (n == len + 1) begin
      exp_w = len; exp_used = len; exp_code = 8'h01;
    end else begin
      exp_w = len; exp_used = len; exp_code = 8'h02;
    end

    chk((n > len + 1) ? "R7 write count" : (n == len + 1) ? "R6 write count" : "R4 write count", wcnt, exp_w);
    for (int i = 0; i < exp_w && i < wcnt && i < 16; i++) begin
      chk("R3 write address", wa[i], (base + i) % 256);
      chk("R3 write data", wd[i], word_of(p, i));
    end
    chk("R5 done pulse count", dcnt, 1);
    if (exp_code == 8'h02)
      chk("R7 overflow completion", got_comp, 16'h0200);
    else if (n == 0)
      chk("R8 empty completion", got_comp, {8'h01, stat[7:0]});
    else
      chk("R5 completion word", got_comp, {8'h01, stat[7:0]});
    chk(n == 0 ? "R8 words used" : (n > len + 1) ? "R7 words used" :
        (n == len + 1) ? "R6 words used" : "R4 words used", got_used, exp_used);
    chk("R5 check write with done", done_with_we, (n >= 1 && n <= len) ? 1 : 0);
    chk("R7 busy after packet", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    start_i    = 1'b0;
    buf_len_i  = '0;
    buf_base_i = '0;
    in_valid_i = 1'b0;
    in_eop_i   = 1'b0;
    in_data_i  = '0;
    clear_mon();
    repeat (3) @(negedge clk);
    chk("R1 reset we", mem_we_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset busy", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset we", mem_we_o, 0);
    chk("R1 after reset busy", busy_o, 0);

    // R9: words while idle
    clear_mon();
    send(1'b0, 16'h1111);
    send(1'b0, 16'h2222);
    send(1'b1, 16'h00FF);
    repeat (2) @(negedge clk);
    chk("R9 idle writes", wcnt, 0);
    chk("R9 idle done", dcnt, 0);
    chk("R9 idle busy", busy_o, 0);

    for (int len = 0; len <= 4; len++)
      for (int n = 0; n <= 7; n++)
        run_pkt(len * 8 + n, len, n);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule